// File: doc/BRIEF.md
# Grant Window Flow Control Checker

This block sits in each input controller of a packet switch and decides whether an arriving packet may enter. The output side sends grants back in-band. A grant is one bit per output port, and it can take up to eight packet cycles to come back. The checker keeps the grant bitmaps of the last eight packet cycles. A packet passes when its destination output appears in that history or in the grant bitmap of the current cycle.

A packet whose destination had no grant inside the window is dropped, and the event sets a sticky violation status bit. Other violation sources in the controller can set the same bit through a separate input. Software clears the bit by writing a one. When checking is disabled, every valid packet is accepted and no violation is raised. The grant history advances only on the packet-cycle strobe.

Top module: `grant_window_checker`

## Requirements
- R1: A synchronous active-high reset clears the grant history to all zeros and clears the violation status. A packet checked right after reset, with no current grant, is dropped.
- R2: While `check_en` is 0, every valid packet gives `pkt_accept`=1 and `pkt_drop`=0. Such packets never set the violation status.
- R3: A packet whose destination bit is set in the current-cycle `grant_map` passes, even if no grant was recorded before.
- R4: `grant_map` is recorded on each cycle where `cycle_tick`=1. A packet for that output passes in each of the next 8 strobed cycles. Once the 8th later strobe has taken effect, the recorded grant no longer passes a packet.
- R5: A valid packet that fails the check while `check_en`=1 gives `pkt_drop`=1 and `pkt_accept`=0 in the same cycle.
- R6: A drop sets `viol_status` at the next clock edge, and the bit stays set until it is cleared.
- R7: `viol_clr`=1 clears `viol_status` at the next edge. If a drop or an external violation occurs in that same cycle, the set wins.
- R8: `ext_viol`=1 sets `viol_status` at the next edge, whatever the packet inputs are.
- R9: While `pkt_valid`=0, both `pkt_accept` and `pkt_drop` are 0.
- R10: Without `cycle_tick`, the grant history does not age. A recorded grant still passes a packet after any number of non-strobed cycles.
- R11: A grant counts only for its own output. Grants to other outputs do not let a packet through to its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | Packet-cycle strobe; records `grant_map` into the history |
| grant_map | input | N_OUTPUTS | Grant bitmap of the current packet cycle, bit i = output i |
| check_en | input | 1 | Enables flow control checking |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_dest | input | $clog2(N_OUTPUTS) | Destination output of the packet |
| ext_viol | input | 1 | Violation from another source; sets the status bit |
| viol_clr | input | 1 | Write-one-to-clear of the status bit |
| pkt_accept | output | 1 | Packet may enter |
| pkt_drop | output | 1 | Packet is discarded for a flow control violation |
| viol_status | output | 1 | Sticky violation status |

## Verification
A wrong history entry shows up as a wrong accept or drop decision. This is seen in the same cycle as a packet for the affected output, or at the strobe where an entry should age out. A shift that is one stage too short or too long flips the decision only at a delay of 8 strobes, so that exact boundary is driven on both sides. A wrong status register shows at `viol_status` one edge after the set or clear cycle. The same-cycle clear-and-set case reveals a priority error.

// File: rtl/grant_window_pkg.sv
package grant_window_pkg;

    localparam int N_OUT_DEF = 32;
    localparam int HIST_DEF  = 8;

    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,
        DEC_PASS = 2'd1,
        DEC_DROP = 2'd2
    } decision_e;

    typedef struct packed {
        logic valid;
        logic enable;
        logic granted;
    } lookup_in_t;

    function automatic decision_e decide(input lookup_in_t li);
        if (!li.valid)
            return DEC_IDLE;
        if (!li.enable || li.granted)
            return DEC_PASS;
        return DEC_DROP;
    endfunction

endpackage

// File: rtl/grant_history.sv
module grant_history #(
    parameter int N_OUTPUTS  = grant_window_pkg::N_OUT_DEF,
    parameter int HIST_DEPTH = grant_window_pkg::HIST_DEF
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cycle_tick,
    input  logic [N_OUTPUTS-1:0]                  grant_map,
    output logic [HIST_DEPTH-1:0][N_OUTPUTS-1:0]  hist
);

    genvar s;
    generate
        for (s = 0; s < HIST_DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    hist[s] <= '0;
                else if (cycle_tick)
                    hist[s] <= (s == 0) ? grant_map : hist[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    // R10
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cycle_tick |=> $stable(hist));

    // R4
    hist_load_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_tick |=> hist[0] == $past(grant_map));

endmodule

// File: rtl/window_lookup.sv
module window_lookup
    import grant_window_pkg::*;
#(
    parameter int N_OUTPUTS  = N_OUT_DEF,
    parameter int HIST_DEPTH = HIST_DEF,
    localparam int DEST_W    = $clog2(N_OUTPUTS)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [N_OUTPUTS-1:0]                  grant_map,
    input  logic [HIST_DEPTH-1:0][N_OUTPUTS-1:0]  hist,
    input  logic                                  check_en,
    input  logic                                  pkt_valid,
    input  logic [DEST_W-1:0]                     pkt_dest,
    output decision_e                             decision
);

    logic [N_OUTPUTS-1:0] window_or;
    logic                 dest_ok;
    lookup_in_t           li;

    always_comb begin
        window_or = grant_map;
        for (int k = 0; k < HIST_DEPTH; k++)
            window_or = window_or | hist[k];
    end

    always_comb begin
        dest_ok = 1'b0;
        if (int'(pkt_dest) < N_OUTPUTS)
            dest_ok = window_or[pkt_dest];
    end

    always_comb begin
        li.valid   = pkt_valid;
        li.enable  = check_en;
        li.granted = dest_ok;
        decision   = decide(li);
    end

    // R2
    no_drop_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !check_en |-> decision != DEC_DROP);

    // R9
    idle_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |-> decision == DEC_IDLE);

    // R3
    current_grant_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && grant_map[pkt_dest]) |-> decision == DEC_PASS);

endmodule

// File: rtl/viol_status_reg.sv
module viol_status_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic status
);

    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (set_evt)
            status <= 1'b1;
        else if (clr_req)
            status <= 1'b0;
    end

    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> status);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_evt) |=> !status);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !set_evt) |=> status == $past(status));

endmodule

// File: rtl/grant_window_checker.sv
module grant_window_checker
    import grant_window_pkg::*;
#(
    parameter int N_OUTPUTS  = N_OUT_DEF,
    parameter int HIST_DEPTH = HIST_DEF,
    localparam int DEST_W    = $clog2(N_OUTPUTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cycle_tick,
    input  logic [N_OUTPUTS-1:0] grant_map,
    input  logic                 check_en,
    input  logic                 pkt_valid,
    input  logic [DEST_W-1:0]    pkt_dest,
    input  logic                 ext_viol,
    input  logic                 viol_clr,
    output logic                 pkt_accept,
    output logic                 pkt_drop,
    output logic                 viol_status
);

    logic [HIST_DEPTH-1:0][N_OUTPUTS-1:0] hist;
    decision_e                            decision;

    grant_history #(
        .N_OUTPUTS (N_OUTPUTS),
        .HIST_DEPTH(HIST_DEPTH)
    ) u_hist (
        .clk       (clk),
        .rst       (rst),
        .cycle_tick(cycle_tick),
        .grant_map (grant_map),
        .hist      (hist)
    );

    window_lookup #(
        .N_OUTPUTS (N_OUTPUTS),
        .HIST_DEPTH(HIST_DEPTH)
    ) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .grant_map(grant_map),
        .hist     (hist),
        .check_en (check_en),
        .pkt_valid(pkt_valid),
        .pkt_dest (pkt_dest),
        .decision (decision)
    );

    assign pkt_accept = (decision == DEC_PASS);
    assign pkt_drop   = (decision == DEC_DROP);

    viol_status_reg u_status (
        .clk    (clk),
        .rst    (rst),
        .set_evt(pkt_drop | ext_viol),
        .clr_req(viol_clr),
        .status (viol_status)
    );

    // R5
    accept_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pkt_accept && pkt_drop));

    // R8
    ext_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ext_viol |=> viol_status);

endmodule

// File: tb/grant_window_checker_bench.sv
module grant_window_checker_bench;

    localparam int N  = 32;
    localparam int DW = 5;
    localparam int NV = 28;

    typedef struct packed {
        logic          tick;
        logic          en;
        logic          valid;
        logic          ext;
        logic          clr;
        logic [N-1:0]  grant;
        logic [DW-1:0] dest;
        logic          acc;
        logic          drop;
        logic          st;
    } vec_t;

    // fields: tick en valid ext clr grant dest | acc drop status(before edge)
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd3, 1'b0,1'b1,1'b0}, // 0  R1 R5
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,       5'd3, 1'b0,1'b0,1'b1}, // 1  R6 R9
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'h0,       5'd0, 1'b0,1'b0,1'b1}, // 2  R6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,       5'd0, 1'b0,1'b0,1'b0}, // 3  R7
        '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h20,      5'd5, 1'b1,1'b0,1'b0}, // 4  R3
        '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h10,      5'd5, 1'b0,1'b1,1'b0}, // 5  R11
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'h0,       5'd0, 1'b0,1'b0,1'b1}, // 6  R6
        '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h80,      5'd0, 1'b0,1'b0,1'b0}, // 7  R4 record
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 8  R4 delay 1
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 9
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 10
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 11
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 12
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 13
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 14
        '{1'b1,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b1,1'b0,1'b0}, // 15 R4 delay 8
        '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd7, 1'b0,1'b1,1'b0}, // 16 R4 aged out
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'h0,       5'd0, 1'b0,1'b0,1'b1}, // 17 R6
        '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h4,       5'd0, 1'b0,1'b0,1'b0}, // 18
        '{1'b0,1'b1,1'b1,1'b0,1'b0,32'h0,       5'd2, 1'b1,1'b0,1'b0}, // 19 R4
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,       5'd9, 1'b1,1'b0,1'b0}, // 20 R2
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,       5'd9, 1'b1,1'b0,1'b0}, // 21 R2
        '{1'b0,1'b1,1'b0,1'b1,1'b0,32'h0,       5'd0, 1'b0,1'b0,1'b0}, // 22 R8
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'h0,       5'd0, 1'b0,1'b0,1'b1}, // 23 R8
        '{1'b0,1'b1,1'b1,1'b0,1'b1,32'h0,       5'd20,1'b0,1'b1,1'b0}, // 24 R7 clr+drop
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,       5'd0, 1'b0,1'b0,1'b1}, // 25 R7 set wins
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'h0,       5'd0, 1'b0,1'b0,1'b1}, // 26
        '{1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,       5'd0, 1'b0,1'b0,1'b0}  // 27 R7
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cycle_tick;
    logic [N-1:0]  grant_map;
    logic          check_en;
    logic          pkt_valid;
    logic [DW-1:0] pkt_dest;
    logic          ext_viol;
    logic          viol_clr;
    logic          pkt_accept;
    logic          pkt_drop;
    logic          viol_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    grant_window_checker u_grant_window_checker (
        .clk        (clk),
        .rst        (rst),
        .cycle_tick (cycle_tick),
        .grant_map  (grant_map),
        .check_en   (check_en),
        .pkt_valid  (pkt_valid),
        .pkt_dest   (pkt_dest),
        .ext_viol   (ext_viol),
        .viol_clr   (viol_clr),
        .pkt_accept (pkt_accept),
        .pkt_drop   (pkt_drop),
        .viol_status(viol_status)
    );

    function automatic string tag_of(input int idx);
        case (idx)
            0:            return "R1/R5";
            1:            return "R9/R6";
            2, 6, 17:     return "R6";
            3, 24, 25:    return "R7";
            4:            return "R3";
            5:            return "R11";
            20, 21:       return "R2";
            22, 23:       return "R8";
            default:      return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic e, input logic v,
                         input logic x, input logic c, input logic [N-1:0] g,
                         input logic [DW-1:0] d);
        cycle_tick = t; check_en = e; pkt_valid = v;
        ext_viol = x; viol_clr = c; grant_map = g; pkt_dest = d;
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 1, 0, 0, 0, '0, '0);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // table walk: inputs set at negedge, outputs sampled 1 ns later
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].tick, VECS[i].en, VECS[i].valid, VECS[i].ext,
                  VECS[i].clr, VECS[i].grant, VECS[i].dest);
            #1;
            check(tag_of(i), $sformatf("vec %0d accept", i), pkt_accept, VECS[i].acc);
            check(tag_of(i), $sformatf("vec %0d drop", i), pkt_drop, VECS[i].drop);
            check(tag_of(i), $sformatf("vec %0d status", i), viol_status, VECS[i].st);
            @(negedge clk);
        end

        // R10: recorded grant survives many non-strobed cycles
        drive(1, 1, 0, 0, 0, 32'h800, '0);
        @(negedge clk);
        drive(0, 1, 0, 0, 0, '0, '0);
        repeat (12) @(negedge clk);
        drive(0, 1, 1, 0, 0, '0, 5'd11);
        #1;
        check("R10", "accept after idle cycles", pkt_accept, 1'b1);
        check("R10", "no drop after idle cycles", pkt_drop, 1'b0);
        @(negedge clk);

        // R1: reset clears history and status
        drive(0, 1, 0, 1, 0, '0, '0);
        @(negedge clk);
        rst = 1'b1;
        drive(0, 1, 0, 0, 0, '0, '0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        drive(0, 1, 1, 0, 0, '0, 5'd11);
        #1;
        check("R1", "status after reset", viol_status, 1'b0);
        check("R1", "drop after reset", pkt_drop, 1'b1);
        check("R1", "accept after reset", pkt_accept, 1'b0);
        @(negedge clk);
        drive(0, 1, 0, 0, 0, '0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule